// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer with Posted Register Writes

This block is a watchdog timer that lives in a slow timer clock domain and is programmed from a faster bus clock domain. It has four write-only registers: control, load, trigger and key. Each bus write is posted: it is held on the bus side and handed across to the slow domain by a toggle handshake. A status vector shows one pending bit for each register while its write is in flight. A second write to a register whose previous write is still in flight is dropped.

In the slow domain an up-counter runs while the watchdog is armed. It advances on every slow cycle, or once every 2^N slow cycles when the prescaler is on. Software services the watchdog by writing the trigger register with a value that differs from the previous one, which copies the load value into the counter. If the counter overflows, the reset output pulses for a fixed number of slow cycles and the counter restarts from the load value. The watchdog is armed and disarmed only by a two-word key sequence written to the key register.

Top module: `key_watchdog`

## Requirements
- R1: Writing 0xBBBB and then 0x4444 to the key register (address 3, low 16 bits of the data) sets `armed` to 1.
- R2: Writing 0xAAAA and then 0x5555 to the key register sets `armed` to 0.
- R3: If the word after 0xBBBB is not 0x4444, or the word after 0xAAAA is not 0x5555, the sequence is abandoned and `armed` keeps its value. A later lone 0x4444 or 0x5555 has no effect.
- R4: `pend[i]` is set from the bus cycle after a write to address i is accepted (0 control, 1 load, 2 trigger, 3 key) until that write has crossed into the slow domain and been acknowledged. The other pending bits are not affected.
- R5: A bus write to a register whose pending bit is set is ignored.
- R6: A trigger write whose value differs from the last trigger value copies the load register into the counter. A repeated value has no effect, and a load write alone does not change the counter. The last trigger value is 0 after reset.
- R7: While armed with the prescaler off, the counter increases by one on every slow clock cycle. While disarmed, it holds its value.
- R8: Control bit 3 enables the prescaler and control bits 2:0 hold N. When the prescaler is enabled, the counter advances once every 2^N slow cycles.
- R9: When the counter overflows from all ones, `wdt_rst` is high for exactly RST_CYC slow cycles and the counter reloads from the load register.
- R10: After reset: `armed` is 0, the counter is 0, `pend` is 0 and `wdt_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| slow_clk | input | 1 | Slow timer clock |
| rst_n | input | 1 | Active-low reset, synchronous in each domain |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 load, 2 trigger, 3 key |
| wr_data | input | CNT_W | Write data |
| pend | output | 4 | Posted-write pending bits, indexed by address |
| armed | output | 1 | Watchdog armed (slow domain) |
| count | output | CNT_W | Counter value (slow domain) |
| wdt_rst | output | 1 | Reset pulse on overflow (slow domain) |

## Verification
The assertions assume that `rst_n` is held low for at least three slow clock cycles, so that both domains start from their reset state. They also assume that the bus holds `wr_en`, `wr_addr` and `wr_data` steady across a bus clock edge. The handshake checks rely on the held write word staying put while its pending bit is set. The stimulus drives every bus input on the falling bus clock edge and keeps reset low across several slow cycles. Apart from the one deliberate back-to-back write, it waits for all pending bits to clear before sampling slow-domain outputs on the falling slow clock edge.

// File: rtl/kwd_pkg.sv
// Package: shared register indices, key words and arm-FSM states for
// the key-sequence watchdog. Assumes key words fit in 16 bits.
package kwd_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LOAD = 2'd1,
        REG_TRIG = 2'd2,
        REG_KEY  = 2'd3
    } kwd_reg_e;

    localparam int          KEY_W      = 16;
    localparam logic [15:0] KEY_ON_1   = 16'hBBBB;
    localparam logic [15:0] KEY_ON_2   = 16'h4444;
    localparam logic [15:0] KEY_OFF_1  = 16'hAAAA;
    localparam logic [15:0] KEY_OFF_2  = 16'h5555;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON1  = 2'd1,
        ST_OFF1 = 2'd2
    } kwd_arm_e;

endpackage

// File: rtl/kwd_post_xing.sv
// Module: one posted-write channel from the bus clock into the slow clock.
// The bus side holds the word and flips a request toggle. The slow side
// synchronises the toggle through two flops, strobes slow_vld for one cycle
// and returns the toggle, which the bus side synchronises back to clear pend.
// Assumes the consumer samples slow_data only while slow_vld is high. The word
// is held steady then, because no new write is accepted while pend is set.
module kwd_post_xing #(
    parameter int DW = 32
) (
    input  logic          bus_clk,
    input  logic          slow_clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          pend,
    output logic          slow_vld,
    output logic [DW-1:0] slow_data
);

    logic          req_t;
    logic [DW-1:0] hold;
    logic          ack_b1, ack_b2;
    logic          req_s1, req_s2, req_s3;

    assign pend      = req_t ^ ack_b2;
    assign slow_vld  = req_s2 ^ req_s3;
    assign slow_data = hold;

    // Accept a bus write only while no earlier write is in flight.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) begin
            req_t <= 1'b0;
            hold  <= '0;
        end else if (wr_req && !pend) begin
            req_t <= ~req_t;
            hold  <= wr_data;
        end
    end

    // Bring the returned toggle back into the bus domain.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) begin
            ack_b1 <= 1'b0;
            ack_b2 <= 1'b0;
        end else begin
            ack_b1 <= req_s3;
            ack_b2 <= ack_b1;
        end
    end

    // Synchronise the request toggle into the slow domain and keep an edge copy.
    always_ff @(posedge slow_clk) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_t;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        pend |=> $stable(hold));

    // R4
    pend_rise_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(pend) |-> $past(wr_req));

endmodule

// File: rtl/kwd_arm_fsm.sv
// Module: the key-sequence recogniser in the slow domain. It moves `armed`
// only after the correct two-word pair. Any other second word drops the
// sequence. Assumes key_vld is a one-cycle strobe for each delivered key write.
module kwd_arm_fsm
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_vld,
    input  logic [KEY_W-1:0] key_word,
    output logic             armed
);

    kwd_arm_e state;

    // Advance the sequence on each delivered key word and update armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            armed <= 1'b0;
        end else if (key_vld) begin
            unique case (state)
                ST_ON1: begin
                    if (key_word == KEY_ON_2) armed <= 1'b1;
                    state <= ST_IDLE;
                end
                ST_OFF1: begin
                    if (key_word == KEY_OFF_2) armed <= 1'b0;
                    state <= ST_IDLE;
                end
                default: begin
                    if (key_word == KEY_ON_1)       state <= ST_ON1;
                    else if (key_word == KEY_OFF_1) state <= ST_OFF1;
                    else                            state <= ST_IDLE;
                end
            endcase
        end
    end

    // R1
    arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_vld |=> $stable(armed));

    // R3
    arm_first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_vld && state == ST_IDLE) |=> $stable(armed));

endmodule

// File: rtl/kwd_count_core.sv
// Module: the slow-domain timer. It holds the control, load and last-trigger
// copies, the prescaler, the up-counter and the overflow pulse stretcher.
// Assumes each *_vld is a one-cycle strobe with its word valid in that cycle.
module kwd_count_core #(
    parameter int CNT_W   = 32,
    parameter int PTV_W   = 3,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             ctrl_vld,
    input  logic [PTV_W:0]   ctrl_word,
    input  logic             load_vld,
    input  logic [CNT_W-1:0] load_word,
    input  logic             trig_vld,
    input  logic [CNT_W-1:0] trig_word,
    output logic [CNT_W-1:0] cnt,
    output logic             wdt_rst
);

    localparam int DIV_W = (1 << PTV_W) - 1;
    localparam int RC_W  = $clog2(RST_CYC + 1);

    logic             pre_en;
    logic [PTV_W-1:0] ptv;
    logic [CNT_W-1:0] load_r;
    logic [CNT_W-1:0] trig_last;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] mask;
    logic [RC_W-1:0]  rst_cnt;
    logic             tick, reload, wrap;

    assign mask    = {DIV_W{1'b1}} >> (DIV_W - int'(ptv));
    assign tick    = armed && (!pre_en || ((div & mask) == mask));
    assign reload  = trig_vld && (trig_word != trig_last);
    assign wrap    = tick && (cnt == {CNT_W{1'b1}});
    assign wdt_rst = (rst_cnt != '0);

    // Capture control, load and last-trigger words as they arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en    <= 1'b0;
            ptv       <= '0;
            load_r    <= '0;
            trig_last <= '0;
        end else begin
            if (ctrl_vld) begin
                pre_en <= ctrl_word[PTV_W];
                ptv    <= ctrl_word[PTV_W-1:0];
            end
            if (load_vld) load_r    <= load_word;
            if (trig_vld) trig_last <= trig_word;
        end
    end

    // Run the prescaler while armed, restarting it on each control write.
    always_ff @(posedge clk) begin
        if (!rst_n)        div <= '0;
        else if (ctrl_vld) div <= '0;
        else if (armed)    div <= div + 1'b1;
    end

    // Reload on a changed trigger or on overflow, otherwise count on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (reload || wrap)  cnt <= load_r;
        else if (tick)            cnt <= cnt + 1'b1;
    end

    // Stretch an overflow into a reset pulse of RST_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rst_cnt <= '0;
        else if (wrap && !reload)   rst_cnt <= RC_W'(RST_CYC);
        else if (rst_cnt != '0)     rst_cnt <= rst_cnt - 1'b1;
    end

    // R7
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !trig_vld) |=> $stable(cnt));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !reload && cnt != {CNT_W{1'b1}}) |=> cnt == $past(cnt) + 1'b1);

    // R9
    rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst) |-> $past(cnt) == {CNT_W{1'b1}});

endmodule

// File: rtl/key_watchdog.sv
// Module: top of the key-sequence watchdog. It decodes bus writes into four
// posted channels (a generate loop, one channel per register) and feeds the
// slow-domain arm FSM and counter core. Assumes CNT_W >= 16 and that rst_n
// stays low for several cycles of both clocks.
module key_watchdog
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int PTV_W   = 3,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [3:0]       pend,
    output logic             armed,
    output logic [CNT_W-1:0] count,
    output logic             wdt_rst
);

    localparam int CTRL_W = PTV_W + 1;

    function automatic int reg_w(input int idx);
        case (idx)
            0:       return CTRL_W;
            3:       return KEY_W;
            default: return CNT_W;
        endcase
    endfunction

    function automatic int reg_o(input int idx);
        int sum = 0;
        for (int j = 0; j < idx; j++) sum += reg_w(j);
        return sum;
    endfunction

    localparam int FLAT_W = reg_o(4);
    localparam int O_CTRL = reg_o(int'(REG_CTRL));
    localparam int O_LOAD = reg_o(int'(REG_LOAD));
    localparam int O_TRIG = reg_o(int'(REG_TRIG));
    localparam int O_KEY  = reg_o(int'(REG_KEY));

    logic [3:0]        slow_vld;
    logic [FLAT_W-1:0] slow_flat;

    // One posted-write channel per register, each sized to its register.
    for (genvar g = 0; g < 4; g++) begin : g_xing
        localparam int W = reg_w(g);
        localparam int O = reg_o(g);
        kwd_post_xing #(.DW(W)) u_xing (
            .bus_clk   (clk),
            .slow_clk  (slow_clk),
            .rst_n     (rst_n),
            .wr_req    (wr_en && (wr_addr == 2'(g))),
            .wr_data   (wr_data[W-1:0]),
            .pend      (pend[g]),
            .slow_vld  (slow_vld[g]),
            .slow_data (slow_flat[O +: W])
        );
    end

    kwd_arm_fsm u_arm (
        .clk      (slow_clk),
        .rst_n    (rst_n),
        .key_vld  (slow_vld[REG_KEY]),
        .key_word (slow_flat[O_KEY +: KEY_W]),
        .armed    (armed)
    );

    kwd_count_core #(
        .CNT_W   (CNT_W),
        .PTV_W   (PTV_W),
        .RST_CYC (RST_CYC)
    ) u_core (
        .clk       (slow_clk),
        .rst_n     (rst_n),
        .armed     (armed),
        .ctrl_vld  (slow_vld[REG_CTRL]),
        .ctrl_word (slow_flat[O_CTRL +: CTRL_W]),
        .load_vld  (slow_vld[REG_LOAD]),
        .load_word (slow_flat[O_LOAD +: CNT_W]),
        .trig_vld  (slow_vld[REG_TRIG]),
        .trig_word (slow_flat[O_TRIG +: CNT_W]),
        .cnt       (count),
        .wdt_rst   (wdt_rst)
    );

    // R10
    rst_idle_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !armed && !$past(armed) |-> !$rose(wdt_rst));

endmodule

// File: tb/sim_key_watchdog.sv
// Bench: directed scenarios for key_watchdog, one task per scenario.
module sim_key_watchdog;

    localparam int CNT_W   = 32;
    localparam int RST_CYC = 8;

    logic             clk = 1'b0;
    logic             slow_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [3:0]       pend;
    logic             armed;
    logic [CNT_W-1:0] count;
    logic             wdt_rst;

    int n_chk  = 0;
    int n_fail = 0;
    int bus_cycles = 0;

    always #2  clk = ~clk;
    always #15 slow_clk = ~slow_clk;

    key_watchdog #(.CNT_W(CNT_W), .PTV_W(3), .RST_CYC(RST_CYC)) u0 (
        .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pend(pend), .armed(armed), .count(count), .wdt_rst(wdt_rst)
    );

    // Watchdog: end a hung run as a failure.
    always @(posedge clk) begin
        bus_cycles <= bus_cycles + 1;
        if (bus_cycles == 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", bus_cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (pend != 4'b0) @(negedge clk);
    endtask

    task automatic wr_wait(input logic [1:0] a, input logic [31:0] d);
        bus_wr(a, d);
        wait_idle();
    endtask

    task automatic t_reset();
        check("R10 pend", 32'(pend), 32'h0);
        check("R10 armed", 32'(armed), 32'h0);
        check("R10 count", count, 32'h0);
        check("R10 wdt_rst", 32'(wdt_rst), 32'h0);
    endtask

    task automatic t_posted();
        bus_wr(2'd1, 32'h100);
        check("R4 pend after load write", 32'(pend), 32'h2);
        bus_wr(2'd1, 32'h200);
        wait_idle();
        wr_wait(2'd2, 32'h1234);
        check("R5 ignored second load / R6 reload", count, 32'h100);
    endtask

    task automatic t_trigger();
        wr_wait(2'd1, 32'h500);
        check("R6 load alone keeps counter", count, 32'h100);
        wr_wait(2'd2, 32'h1234);
        check("R6 repeated trigger ignored", count, 32'h100);
        wr_wait(2'd2, 32'hEDCB);
        check("R6 changed trigger reloads", count, 32'h500);
    endtask

    task automatic t_badkey_on();
        wr_wait(2'd3, 32'hBBBB);
        wr_wait(2'd3, 32'h1234);
        check("R3 wrong second word", 32'(armed), 32'h0);
        wr_wait(2'd3, 32'h4444);
        check("R3 lone second word", 32'(armed), 32'h0);
        check("R3 counter held while disarmed", count, 32'h500);
        wr_wait(2'd3, 32'hBBBB);
        wr_wait(2'd3, 32'h4444);
        check("R1 arm sequence", 32'(armed), 32'h1);
    endtask

    task automatic t_run();
        logic [31:0] c0;
        for (int i = 0; i < 3; i++) begin
            @(negedge slow_clk); c0 = count;
            @(negedge slow_clk);
            check("R7 step of one per slow cycle", count - c0, 32'h1);
        end
    endtask

    task automatic t_disarm();
        logic [31:0] c0;
        wr_wait(2'd3, 32'hAAAA);
        wr_wait(2'd3, 32'h0);
        check("R3 bad disarm keeps armed", 32'(armed), 32'h1);
        wr_wait(2'd3, 32'hAAAA);
        wr_wait(2'd3, 32'h5555);
        check("R2 disarm sequence", 32'(armed), 32'h0);
        @(negedge slow_clk); c0 = count;
        repeat (5) @(negedge slow_clk);
        check("R7 frozen while disarmed", count, c0);
    endtask

    task automatic t_prescale();
        logic [31:0] c0;
        wr_wait(2'd0, 32'h8 | 32'h2);
        wr_wait(2'd3, 32'hBBBB);
        wr_wait(2'd3, 32'h4444);
        @(negedge slow_clk); c0 = count;
        repeat (16) @(negedge slow_clk);
        check("R8 four steps in 16 cycles with N=2", count - c0, 32'h4);
        wr_wait(2'd3, 32'hAAAA);
        wr_wait(2'd3, 32'h5555);
        wr_wait(2'd0, 32'h0);
    endtask

    task automatic t_wrap();
        int hi;
        int guard;
        wr_wait(2'd1, 32'hFFFF_FFF0);
        wr_wait(2'd2, 32'h1234);
        check("R6 reload before wrap", count, 32'hFFFF_FFF0);
        wr_wait(2'd3, 32'hBBBB);
        wr_wait(2'd3, 32'h4444);
        guard = 0;
        @(negedge slow_clk);
        while (!wdt_rst && guard < 200) begin
            @(negedge slow_clk);
            guard++;
        end
        check("R9 reset pulse seen", 32'(wdt_rst), 32'h1);
        check("R9 counter reloaded on wrap", count, 32'hFFFF_FFF0);
        hi = 0;
        while (wdt_rst && hi < 100) begin
            hi++;
            @(negedge slow_clk);
        end
        check("R9 pulse length", 32'(hi), 32'(RST_CYC));
        wr_wait(2'd3, 32'hAAAA);
        wr_wait(2'd3, 32'h5555);
    endtask

    initial begin
        repeat (5) @(negedge slow_clk);
        rst_n = 1'b1;
        @(negedge slow_clk);
        t_reset();
        t_posted();
        t_trigger();
        t_badkey_on();
        t_run();
        t_disarm();
        t_prescale();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule